// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This block decides how bit 6 of a byte address must be scrambled so that tiled surfaces land on the right memory channel. The decision depends on how the memory controller is configured. When the configuration-load strobe is pulsed, the block reads a platform class, a controller configuration word and the top rank-boundary values of the two channels. From these it works out one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces, and holds both in registers.

A separate one-stage pipeline applies the held modes to a stream of requests. Each request carries a byte address and a tiling kind. The result is the address with bit 6 replaced by the XOR of itself and a mode-dependent set of bits taken from 9, 10 and 11. Some configurations cannot be swizzled consistently. For those, a tiled request passes through untouched and a flag reports that tiling was forced off.

Configuration word fields used: bits [1:0] channel arrangement (0 single, 1 dual asymmetric, 2 reserved, 3 dual interleaved), bit 2 channel-XOR disable, bit 3 high-bit (bit 17) XOR select. Platform class: 0 oldest, 1 configuration-word based, 2 or 3 rank-compare based. Mode codes: 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 7 unknown. Tiling codes: 0 linear, 1 X, 2 Y, 3 treated as linear.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: After synchronous reset, mode_x and mode_y both read 7 (unknown) and out_valid is 0.
- R2: With platform class 0, a load gives mode_x=0 and mode_y=0 whatever the other inputs are.
- R3: With platform class 1 and a channel arrangement of 0 or 1, a load gives 0 for both modes.
- R4: With platform class 1, arrangement 3 and bit 2 set, a load gives mode_x=2 and mode_y=1.
- R5: With platform class 1, arrangement 3, bit 2 clear and bit 3 clear, a load gives mode_x=4 and mode_y=3.
- R6: With platform class 1, a load gives 7 for both modes in two cases: arrangement 3 with bit 2 clear and bit 3 set, or arrangement 2.
- R7: With platform class 1, a configuration word of 0xFFFFFFFF loads 7 for both modes, even though its fields would otherwise decode to another mode.
- R8: With platform class 2 or 3, equal rank-boundary values load mode_x=2 and mode_y=1, and unequal values load 0 for both modes.
- R9: The modes change only in the cycle after cfg_load is high. Input changes without a load have no effect on them.
- R10: out_valid equals in_valid delayed by exactly one clock, and out_addr and out_forced_linear belong to that same request.
- R11: An X request uses mode_x and a Y request uses mode_y. Output bit 6 is input bit 6 XOR bit 9 (modes 1 to 4), XOR bit 10 (modes 2 and 4), XOR bit 11 (modes 3 and 4). Every other address bit is unchanged.
- R12: A tiled request whose mode is 7 comes out with an unchanged address and out_forced_linear=1. Every other request has out_forced_linear=0.
- R13: A request with tiling code 0 or 3 comes out with an unchanged address whatever the held modes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe that recomputes and latches the modes |
| plat_class | input | 2 | Platform class selecting the detection rule |
| cfg_word | input | 32 | Memory-controller configuration word |
| rank_top_a | input | RBW | Top rank boundary of channel A |
| rank_top_b | input | RBW | Top rank boundary of channel B |
| mode_x | output | 3 | Held swizzle mode for X tiling |
| mode_y | output | 3 | Held swizzle mode for Y tiling |
| in_valid | input | 1 | Request strobe |
| in_addr | input | AW | Request byte address |
| in_tile | input | 2 | Request tiling code |
| out_valid | output | 1 | Result strobe |
| out_addr | output | AW | Swizzled byte address |
| out_forced_linear | output | 1 | Tiled request downgraded to linear |

## Verification
A wrongly latched mode shows directly on mode_x or mode_y in the cycle after the load. It then corrupts bit 6 of the next X or Y request whose address has bit 9, 10 or 11 set, one cycle after that request is issued. A mode that drifts without a load would show as a changed mode value before any traffic reaches it. The scoreboard compares every result in order, so a dropped, duplicated or late result leaves the expected queue out of step at once.

// File: rtl/bit6_swizzle_unit.sv
module bit6_swizzle_unit #(
  parameter int AW  = 32,
  parameter int RBW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_load,
  input  logic [1:0]     plat_class,
  input  logic [31:0]    cfg_word,
  input  logic [RBW-1:0] rank_top_a,
  input  logic [RBW-1:0] rank_top_b,
  output logic [2:0]     mode_x,
  output logic [2:0]     mode_y,
  input  logic           in_valid,
  input  logic [AW-1:0]  in_addr,
  input  logic [1:0]     in_tile,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr,
  output logic           out_forced_linear
);

  localparam logic [2:0] M_NONE = 3'd0;
  localparam logic [2:0] M_9    = 3'd1;
  localparam logic [2:0] M_9_10 = 3'd2;
  localparam logic [2:0] M_9_11 = 3'd3;
  localparam logic [2:0] M_ALL  = 3'd4;
  localparam logic [2:0] M_UNK  = 3'd7;

  logic [2:0] det_x, det_y, sel_mode;
  logic       tiled, flip, forced;

  always_comb begin
    det_x = M_UNK;
    det_y = M_UNK;
    case (plat_class)
      2'd0: begin
        det_x = M_NONE;
        det_y = M_NONE;
      end
      2'd1: begin
        if (cfg_word != '1) begin
          case (cfg_word[1:0])
            2'd0, 2'd1: begin
              det_x = M_NONE;
              det_y = M_NONE;
            end
            2'd3: begin
              if (cfg_word[2]) begin
                det_x = M_9_10;
                det_y = M_9;
              end else if (!cfg_word[3]) begin
                det_x = M_ALL;
                det_y = M_9_11;
              end
            end
            default: ;
          endcase
        end
      end
      default: begin
        det_x = (rank_top_a == rank_top_b) ? M_9_10 : M_NONE;
        det_y = (rank_top_a == rank_top_b) ? M_9    : M_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_x <= M_UNK;
      mode_y <= M_UNK;
    end else if (cfg_load) begin
      mode_x <= det_x;
      mode_y <= det_y;
    end
  end

  assign tiled    = (in_tile == 2'd1) || (in_tile == 2'd2);
  assign sel_mode = (in_tile == 2'd1) ? mode_x : (in_tile == 2'd2) ? mode_y : M_NONE;
  assign forced   = tiled && (sel_mode == M_UNK);

  always_comb begin
    case (sel_mode)
      M_9:     flip = in_addr[9];
      M_9_10:  flip = in_addr[9] ^ in_addr[10];
      M_9_11:  flip = in_addr[9] ^ in_addr[11];
      M_ALL:   flip = in_addr[9] ^ in_addr[10] ^ in_addr[11];
      default: flip = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid         <= 1'b0;
      out_addr          <= '0;
      out_forced_linear <= 1'b0;
    end else begin
      out_valid         <= in_valid;
      out_addr          <= in_addr ^ {{(AW-7){1'b0}}, flip, 6'b0};
      out_forced_linear <= in_valid && forced;
    end
  end

endmodule

// File: rtl/bit6_swizzle_unit_chk.sv
module bit6_swizzle_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_load,
  input logic [2:0]    mode_x,
  input logic [2:0]    mode_y,
  input logic          in_valid,
  input logic [AW-1:0] in_addr,
  input logic [1:0]    in_tile,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic          out_forced_linear
);

  localparam logic [AW-1:0] B6 = {{(AW-7){1'b0}}, 1'b1, 6'b0};

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst)
      p_reset_unknown_r1: assert (mode_x == 3'd7 && mode_y == 3'd7 && !out_valid);
  end

  p_hold_without_load_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(mode_x) && $stable(mode_y));

  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_only_bit6_moves_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_addr & ~B6) == ($past(in_addr) & ~B6));

  p_y_never_bit10_r11: assert property (@(posedge clk) disable iff (rst)
    mode_y != 3'd2 && mode_y != 3'd4);

  p_forced_needs_valid_r12: assert property (@(posedge clk) disable iff (rst)
    out_forced_linear |-> out_valid);

  p_linear_passthru_r13: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_tile == 2'd0 || in_tile == 2'd3) |=>
      out_addr == $past(in_addr) && !out_forced_linear);

endmodule

bind bit6_swizzle_unit bit6_swizzle_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .mode_x(mode_x), .mode_y(mode_y),
  .in_valid(in_valid), .in_addr(in_addr), .in_tile(in_tile),
  .out_valid(out_valid), .out_addr(out_addr), .out_forced_linear(out_forced_linear)
);

// File: tb/bit6_swizzle_unit_tb_top.sv
module bit6_swizzle_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int RBW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [1:0] plat_class = 2'd0;
  logic [31:0] cfg_word = '0;
  logic [RBW-1:0] rank_top_a = '0, rank_top_b = '0;
  logic [2:0] mode_x, mode_y;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0] in_tile = 2'd0;
  logic out_valid, out_forced_linear;
  logic [AW-1:0] out_addr;

  int total = 0, bad = 0;
  logic [2:0] cur_x = 3'd7, cur_y = 3'd7;
  logic [AW-1:0] q_addr[$];
  logic q_forced[$];
  string q_tag[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit6_swizzle_unit #(.AW(AW), .RBW(RBW)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .plat_class(plat_class),
    .cfg_word(cfg_word), .rank_top_a(rank_top_a), .rank_top_b(rank_top_b),
    .mode_x(mode_x), .mode_y(mode_y), .in_valid(in_valid), .in_addr(in_addr),
    .in_tile(in_tile), .out_valid(out_valid), .out_addr(out_addr),
    .out_forced_linear(out_forced_linear));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input logic [2:0] m);
    logic b;
    b = 1'b0;
    if (m >= 3'd1 && m <= 3'd4) b ^= a[9];
    if (m == 3'd2 || m == 3'd4) b ^= a[10];
    if (m == 3'd3 || m == 3'd4) b ^= a[11];
    model = a;
    model[6] = a[6] ^ b;
  endfunction

  task automatic send(input logic [AW-1:0] a, input logic [1:0] t, input string tag);
    logic [2:0] m;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_tile = t;
    m = (t == 2'd1) ? cur_x : (t == 2'd2) ? cur_y : 3'd0;
    if ((t == 2'd1 || t == 2'd2) && m == 3'd7) begin
      q_addr.push_back(a); q_forced.push_back(1'b1);
    end else begin
      q_addr.push_back(model(a, m)); q_forced.push_back(1'b0);
    end
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic burst(input string tag);
    logic [AW-1:0] pats[6] = '{32'h0000_0200, 32'h0000_0400, 32'h0000_0800,
                               32'h0000_0E40, 32'hA5A5_5A5A, 32'h1234_0B4C};
    for (int i = 0; i < 6; i++) begin
      for (int t = 0; t < 4; t++) send(pats[i], t[1:0], tag);
    end
    idle(3);
  endtask

  task automatic load(input logic [1:0] pc, input logic [31:0] w, input logic [RBW-1:0] ra,
                      input logic [RBW-1:0] rb, input logic [2:0] ex, input logic [2:0] ey,
                      input string tag);
    @(negedge clk);
    plat_class = pc; cfg_word = w; rank_top_a = ra; rank_top_b = rb; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(mode_x == ex, {tag, " mode_x"}, 64'(mode_x), 64'(ex));
    chk(mode_y == ey, {tag, " mode_y"}, 64'(mode_y), 64'(ey));
    cur_x = ex; cur_y = ey;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R10 unexpected result", 64'(out_addr), 64'd0);
        end else begin
          logic [AW-1:0] ea;
          logic ef;
          string tg;
          ea = q_addr.pop_front(); ef = q_forced.pop_front(); tg = q_tag.pop_front();
          chk(out_addr == ea, {tg, " addr"}, 64'(out_addr), 64'(ea));
          chk(out_forced_linear == ef, {tg, " R12 forced"}, 64'(out_forced_linear), 64'(ef));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode_x == 3'd7, "R1 reset mode_x", 64'(mode_x), 64'd7);
    chk(mode_y == 3'd7, "R1 reset mode_y", 64'(mode_y), 64'd7);
    chk(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);

    burst("R12 unknown after reset");

    // R10 exact latency
    send(32'h0000_0E40, 2'd1, "R10 single");
    @(posedge clk); #2;
    chk(out_valid == 1'b1, "R10 valid one cycle later", 64'(out_valid), 64'd1);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #2;
    chk(out_valid == 1'b0, "R10 valid drops", 64'(out_valid), 64'd0);
    idle(2);

    load(2'd0, 32'h0000_0007, 16'h10, 16'h20, 3'd0, 3'd0, "R2 oldest");
    burst("R2 traffic");
    load(2'd1, 32'h0000_0000, 16'h0, 16'h0, 3'd0, 3'd0, "R3 single");
    load(2'd1, 32'h0000_0005, 16'h0, 16'h0, 3'd0, 3'd0, "R3 asymmetric");
    load(2'd1, 32'h0000_0007, 16'h0, 16'h0, 3'd2, 3'd1, "R4 xor off");
    burst("R11 R13 modes 2/1");
    load(2'd1, 32'h0000_0003, 16'h0, 16'h0, 3'd4, 3'd3, "R5 bit11");
    burst("R11 R13 modes 4/3");
    load(2'd1, 32'h0000_000B, 16'h0, 16'h0, 3'd7, 3'd7, "R6 bit17");
    burst("R12 R13 unknown");
    load(2'd1, 32'h0000_0002, 16'h0, 16'h0, 3'd7, 3'd7, "R6 reserved");
    load(2'd1, 32'h0000_0007, 16'h0, 16'h0, 3'd2, 3'd1, "R4 reload");
    load(2'd1, 32'hFFFF_FFFF, 16'h0, 16'h0, 3'd7, 3'd7, "R7 all ones");
    load(2'd2, 32'h0, 16'h0123, 16'h0123, 3'd2, 3'd1, "R8 equal");
    load(2'd3, 32'h0, 16'h0123, 16'h0124, 3'd0, 3'd0, "R8 differ");
    load(2'd3, 32'h0, 16'h8000, 16'h8000, 3'd2, 3'd1, "R8 equal class3");

    // R9: inputs change without a load
    @(negedge clk);
    plat_class = 2'd1; cfg_word = 32'h0000_000B; rank_top_a = 16'h1; rank_top_b = 16'h2;
    idle(3);
    chk(mode_x == 3'd2, "R9 hold mode_x", 64'(mode_x), 64'd2);
    chk(mode_y == 3'd1, "R9 hold mode_y", 64'(mode_y), 64'd1);
    burst("R9 R11 traffic after hold");

    idle(2);
    chk(q_addr.size() == 0, "R10 all results seen", 64'(q_addr.size()), 64'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule